// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames from a byte stream into host memory through a ring of in-memory receive descriptors. It sees the frame start and reads the flag word of the descriptor at the current ring index. If the ownership bit shows that the descriptor was handed to the block, it reads the buffer address and the buffer length. It then packs the frame bytes into 16-bit words and writes them to the buffer. It finishes by writing back the received length and a completed flag byte, and this write returns the descriptor to the host. It reaches memory through a simple word-wide master port with a request/acknowledge handshake.

Each descriptor takes four 16-bit words, 8 bytes in all, and sits at ring base + 8 × index. The offsets are: +0 holds the low 16 bits of the buffer address. +2 holds the flag byte in bits 15:8 and the upper 8 buffer-address bits in bits 7:0. +4 holds the buffer length as a negative number. +6 holds the message length. A register block supplies the ring base low word, a ring-length word and a run control. The ring-length word carries the log2 of the ring size in bits 15:13 and the upper 8 ring-base bits in bits 7:0. Each finished frame raises a one-cycle interrupt pulse. A frame that finds no descriptor ready raises a missed-frame pulse instead.

The stream presents each frame with its 4 FCS bytes at the end. A CRC-valid flag and a framing-error flag arrive together with the last byte.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame start, with run high, makes the first memory access a read of the flag word at ring base + 8 × index + 2. The ring base is {ring_len_word[7:0], ring_base_lo}.
- R2: The flag word may show the descriptor as host-owned (bit 15 clear). The frame is then consumed with no memory write and no interrupt. rx_miss pulses for one cycle, and the ring index stays the same.
- R3: The buffer capacity is 4096 minus bits 11:0 of the length word at offset +4. Frame byte k goes to the word at buffer address + (k with bit 0 cleared). The buffer address is {flag word bits 7:0, word at +0}. The lane is k[0]: lane 0 is bits 7:0 under mem_be[0], lane 1 is bits 15:8 under mem_be[1].
- R4: Bytes beyond the buffer capacity are never written. A frame that exceeds the capacity completes with OFLO (flag bit 4) and ERR set.
- R5: The word at +6 is written with the number of bytes stored, including the FCS bytes, in bits 11:0. Bits 15:12 are zero, and this write comes before the flag write.
- R6: The flag word written at +2 has bits 7:0 equal to the upper address byte read. Its flag byte is {OWN=0, ERR, FRAM, OFLO, CRC, BUFF=0, STP=1, ENP=1}, from bit 7 down to bit 0.
- R7: CRC (bit 3) is set when rx_crc_ok is low with the last byte. FRAM (bit 5) is set when rx_frame_err is high with the last byte. ERR (bit 6) is the OR of BUFF, CRC, OFLO and FRAM.
- R8: After each completed descriptor the index becomes (index + 1) AND (2^L − 1), where L = ring_len_word[15:13].
- R9: rx_int is high for exactly one cycle, in the cycle after the flag write is acknowledged.
- R10: While run is low, a frame that arrives is consumed with no memory access and no pulse.
- R11: mem_req holds its address and direction until mem_ack. rx_ready is low while a memory access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start (1) / stop (0) control |
| ring_base_lo | input | 16 | Low 16 bits of ring base address |
| ring_len_word | input | 16 | Bits 15:13 log2 ring size, bits 7:0 upper ring base bits |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_crc_ok | input | 1 | CRC-valid flag, taken with the last byte |
| rx_frame_err | input | 1 | Framing-error flag, taken with the last byte |
| rx_ready | output | 1 | Block accepts the stream byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the 16-bit word |
| mem_be | output | 2 | Byte-lane enables for writes |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| rx_int | output | 1 | One-cycle pulse per completed frame |
| rx_miss | output | 1 | One-cycle pulse per frame dropped for lack of a descriptor |

## Verification
The assertions check the following on every cycle. The memory handshake stays stable and the stream stalls during accesses. No data write lands outside the buffer. The released flag word has ownership clear, the ERR summary matches the error bits, and the interrupt is a single pulse after the release. The index steps by one under the mask, and a missed frame never touches memory. The bench scenarios cover the rest. They show the byte lanes and the buffer contents, including the untouched sentinel bytes past the end. They show the reported length, the exact error flags across frame lengths and odd or even capacities, ring wrap under two ring sizes, and the order of first access. They also show that frames arriving while stopped, or facing a host-owned descriptor, leave memory unchanged.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ADDR_W     = 24;
  localparam int WORD_W     = 16;
  localparam int RING_LOG_W = 3;
  localparam int IDX_W      = (1 << RING_LOG_W) - 1;
  localparam int CNT_W      = 13;

  localparam int FL_OWN  = 7;
  localparam int FL_ERR  = 6;
  localparam int FL_FRAM = 5;
  localparam int FL_OFLO = 4;
  localparam int FL_CRC  = 3;
  localparam int FL_BUFF = 2;
  localparam int FL_STP  = 1;
  localparam int FL_ENP  = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_FLAG, S_RD_ADDR, S_RD_LEN, S_DATA,
    S_WR_DATA, S_DRAIN, S_SKIP, S_WB_LEN, S_WB_FLAG
  } rxr_state_e;

  function automatic logic [CNT_W-1:0] buf_capacity(input logic [11:0] neg_len);
    return 13'h1000 - {1'b0, neg_len};
  endfunction

  function automatic logic [7:0] done_flags(input logic crc_bad, input logic fram_bad,
                                            input logic oflo);
    logic [7:0] f;
    f = 8'h00;
    f[FL_STP]  = 1'b1;
    f[FL_ENP]  = 1'b1;
    f[FL_CRC]  = crc_bad;
    f[FL_FRAM] = fram_bad;
    f[FL_OFLO] = oflo;
    f[FL_BUFF] = 1'b0;
    f[FL_ERR]  = crc_bad | fram_bad | oflo;
    f[FL_OWN]  = 1'b0;
    return f;
  endfunction
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
  import rxr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RING_LOG_W-1:0] ring_log,
  input  logic [ADDR_W-1:0]     ring_base,
  input  logic                  advance,
  output logic [IDX_W-1:0]      cur_idx,
  output logic [IDX_W-1:0]      ring_mask,
  output logic [ADDR_W-1:0]     desc_base
);
  logic [IDX_W-1:0] idx_q;

  assign ring_mask = ~({IDX_W{1'b1}} << ring_log);
  assign cur_idx   = idx_q & ring_mask;
  assign desc_base = ring_base + {{(ADDR_W-IDX_W-3){1'b0}}, cur_idx, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= (cur_idx + IDX_W'(1)) & ring_mask;
  end
endmodule

// File: rtl/rxr_byte_acc.sv
module rxr_byte_acc
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [7:0]        byte_in,
  input  logic [ADDR_W-1:0] buf_addr,
  output logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] word,
  output logic [1:0]        be,
  output logic [ADDR_W-1:0] word_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      word      <= '0;
      be        <= '0;
      word_addr <= '0;
    end else if (clear) begin
      cnt  <= '0;
      word <= '0;
      be   <= '0;
    end else if (take) begin
      if (!cnt[0]) begin
        word      <= {8'h00, byte_in};
        be        <= 2'b01;
        word_addr <= buf_addr + {{(ADDR_W-CNT_W){1'b0}}, cnt};
      end else begin
        word[15:8] <= byte_in;
        be[1]      <= 1'b1;
      end
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [15:0]       ring_base_lo,
  input  logic [15:0]       ring_len_word,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_crc_ok,
  input  logic              rx_frame_err,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              rx_int,
  output logic              rx_miss
);
  rxr_state_e        st;
  logic [ADDR_W-1:0] desc_base, buf_addr, acc_addr;
  logic [IDX_W-1:0]  cur_idx, ring_mask;
  logic [7:0]        addr_hi;
  logic [15:0]       addr_lo;
  logic [CNT_W-1:0]  buf_cap, byte_cnt;
  logic [WORD_W-1:0] acc_word;
  logic [1:0]        acc_be;
  logic              crc_bad, fram_bad, oflo, pend_last;
  logic              unused_ring_bits;

  // named internal events
  logic byte_in, take, ovf_hit, flush_now, data_wr, wb_flag_fire, acc_clear, miss_now;

  assign unused_ring_bits = ^ring_len_word[12:8];
  assign buf_addr     = {addr_hi, addr_lo};
  assign byte_in      = (st == S_DATA) && rx_valid;
  assign take         = byte_in && (byte_cnt != buf_cap);
  assign ovf_hit      = byte_in && (byte_cnt == buf_cap);
  assign flush_now    = byte_cnt[0] | rx_last | ((byte_cnt + CNT_W'(1)) == buf_cap);
  assign data_wr      = (st == S_WR_DATA);
  assign wb_flag_fire = (st == S_WB_FLAG) && mem_ack;
  assign acc_clear    = (st == S_RD_FLAG) && mem_ack;
  assign miss_now     = (st == S_RD_FLAG) && mem_ack && !mem_rdata[8 + FL_OWN];

  rxr_ring_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_log  (ring_len_word[15:13]),
    .ring_base ({ring_len_word[7:0], ring_base_lo}),
    .advance   (wb_flag_fire),
    .cur_idx   (cur_idx),
    .ring_mask (ring_mask),
    .desc_base (desc_base)
  );

  rxr_byte_acc u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (acc_clear),
    .take      (take),
    .byte_in   (rx_data),
    .buf_addr  (buf_addr),
    .cnt       (byte_cnt),
    .word      (acc_word),
    .be        (acc_be),
    .word_addr (acc_addr)
  );

  assign rx_ready = (st == S_DATA) || (st == S_DRAIN) || (st == S_SKIP);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_base;
    mem_be    = 2'b11;
    mem_wdata = '0;
    unique case (st)
      S_RD_FLAG: begin mem_req = 1'b1; mem_addr = desc_base + ADDR_W'(2); end
      S_RD_ADDR: begin mem_req = 1'b1; mem_addr = desc_base; end
      S_RD_LEN:  begin mem_req = 1'b1; mem_addr = desc_base + ADDR_W'(4); end
      S_WR_DATA: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = acc_addr;
        mem_be = acc_be; mem_wdata = acc_word;
      end
      S_WB_LEN: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_base + ADDR_W'(6);
        mem_wdata = {4'h0, byte_cnt[11:0]};
      end
      S_WB_FLAG: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_base + ADDR_W'(2);
        mem_wdata = {done_flags(crc_bad, fram_bad, oflo), addr_hi};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_hi   <= '0;
      addr_lo   <= '0;
      buf_cap   <= '0;
      crc_bad   <= 1'b0;
      fram_bad  <= 1'b0;
      oflo      <= 1'b0;
      pend_last <= 1'b0;
      rx_int    <= 1'b0;
      rx_miss   <= 1'b0;
    end else begin
      rx_int  <= wb_flag_fire;
      rx_miss <= miss_now;
      unique case (st)
        S_IDLE: if (rx_valid) begin
          if (run) begin
            st        <= S_RD_FLAG;
            crc_bad   <= 1'b0;
            fram_bad  <= 1'b0;
            oflo      <= 1'b0;
            pend_last <= 1'b0;
          end else begin
            st <= S_SKIP;
          end
        end
        S_RD_FLAG: if (mem_ack) begin
          if (mem_rdata[8 + FL_OWN]) begin
            addr_hi <= mem_rdata[7:0];
            st      <= S_RD_ADDR;
          end else begin
            st <= S_SKIP;
          end
        end
        S_RD_ADDR: if (mem_ack) begin
          addr_lo <= mem_rdata;
          st      <= S_RD_LEN;
        end
        S_RD_LEN: if (mem_ack) begin
          buf_cap <= buf_capacity(mem_rdata[11:0]);
          st      <= S_DATA;
        end
        S_DATA: begin
          if (take) begin
            pend_last <= rx_last;
            if (rx_last) begin
              crc_bad  <= !rx_crc_ok;
              fram_bad <= rx_frame_err;
            end
            if (flush_now) st <= S_WR_DATA;
          end else if (ovf_hit) begin
            oflo <= 1'b1;
            if (rx_last) begin
              crc_bad  <= !rx_crc_ok;
              fram_bad <= rx_frame_err;
              st       <= S_WB_LEN;
            end else begin
              st <= S_DRAIN;
            end
          end
        end
        S_WR_DATA: if (mem_ack) st <= pend_last ? S_WB_LEN : S_DATA;
        S_DRAIN: if (rx_valid && rx_last) begin
          crc_bad  <= !rx_crc_ok;
          fram_bad <= rx_frame_err;
          st       <= S_WB_LEN;
        end
        S_SKIP:    if (rx_valid && rx_last) st <= S_IDLE;
        S_WB_LEN:  if (mem_ack) st <= S_WB_FLAG;
        S_WB_FLAG: if (mem_ack) st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk
  import rxr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              rx_ready,
  input logic              rx_int,
  input logic              rx_miss,
  input logic              data_wr,
  input logic              wb_flag_fire,
  input logic [ADDR_W-1:0] buf_addr,
  input logic [CNT_W-1:0]  buf_cap,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [IDX_W-1:0]  ring_mask
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_stall_during_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rx_ready);

  p_within_buffer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> ((mem_addr - buf_addr) < {{(ADDR_W-CNT_W){1'b0}}, buf_cap}));

  p_release_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_flag_fire |-> mem_we && !mem_wdata[15] && (mem_wdata[9:8] == 2'b11));

  p_err_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_flag_fire |-> (mem_wdata[14] == (|mem_wdata[13:10])));

  p_int_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_flag_fire |=> rx_int);

  p_int_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |=> !rx_int);

  p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_miss |-> !mem_req && !rx_int);

  p_index_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |-> cur_idx == ((($past(cur_idx)) + IDX_W'(1)) & ring_mask));
endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .rx_ready     (rx_ready),
  .rx_int       (rx_int),
  .rx_miss      (rx_miss),
  .data_wr      (data_wr),
  .wb_flag_fire (wb_flag_fire),
  .buf_addr     (buf_addr),
  .buf_cap      (buf_cap),
  .cur_idx      (cur_idx),
  .ring_mask    (ring_mask)
);

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b1;
  logic [15:0] ring_base_lo = 16'h0100;
  logic [15:0] ring_len_word = {3'd2, 13'h0000};
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_crc_ok = 1'b1, rx_frame_err = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready, mem_req, mem_we, mem_ack, rx_int, rx_miss;
  logic [23:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem [0:4095];
  logic        host_we = 1'b0;
  logic [11:0] host_a = '0;
  logic [15:0] host_d = '0;
  logic [1:0]  dly;
  logic [3:0]  seq;
  int          int_cnt, miss_cnt, wr_cnt, hs_bad;
  logic        want_first;
  logic [23:0] first_addr;
  logic        prev_pend;
  logic [23:0] prev_addr;
  logic        prev_we;

  int total = 0, bad = 0;
  int exp_idx = 0, ring_mask_b = 3;

  always #2.5 clk = ~clk;

  rx_ring_writer uut (.*);

  // memory model and monitor
  always @(posedge clk) begin
    if (host_we) mem[host_a] <= host_d;
    if (!rst_n) begin
      mem_ack <= 1'b0; dly <= 2'd1; seq <= 4'd0;
      int_cnt <= 0; miss_cnt <= 0; wr_cnt <= 0; hs_bad <= 0;
      want_first <= 1'b1; first_addr <= '0; prev_pend <= 1'b0;
      prev_addr <= '0; prev_we <= 1'b0; mem_rdata <= '0;
    end else begin
      if (rx_int)  int_cnt  <= int_cnt + 1;
      if (rx_miss) miss_cnt <= miss_cnt + 1;
      if (rx_int || rx_miss) want_first <= 1'b1;
      if (mem_req && want_first) begin
        want_first <= 1'b0;
        first_addr <= mem_req && !mem_we ? mem_addr : 24'hFFFFFF;
      end
      if (prev_pend && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
        hs_bad <= hs_bad + 1;
      prev_pend <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
      prev_we   <= mem_we;
      if (mem_req && !mem_ack) begin
        if (dly == 2'd0) begin
          mem_ack <= 1'b1;
          if (mem_we) begin
            wr_cnt <= wr_cnt + 1;
            if (mem_be[0]) mem[mem_addr[12:1]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[12:1]][15:8] <= mem_wdata[15:8];
          end else begin
            mem_rdata <= mem[mem_addr[12:1]];
          end
          dly <= seq[1:0];
          seq <= seq + 4'd3;
        end else begin
          dly <= dly - 2'd1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input int f, input int k);
    return 8'((f * 7) + (k * 13) + 1);
  endfunction

  function automatic int desc_w(input int i);
    return (16'h0100 + 8 * i) / 2;
  endfunction

  function automatic int buf_w(input int i);
    return (16'h1000 + 16'h100 * i) / 2;
  endfunction

  task automatic hw(input int waddr, input logic [15:0] d);
    host_we = 1'b1; host_a = 12'(waddr); host_d = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic arm(input int i, input int cap, input logic own);
    for (int w = 0; w < (cap + 1) / 2 + 2; w++) hw(buf_w(i) + w, 16'hA5C3);
    hw(desc_w(i) + 0, 16'(16'h1000 + 16'h100 * i));
    hw(desc_w(i) + 1, own ? 16'h8000 : 16'h0000);
    hw(desc_w(i) + 2, 16'hF000 | 16'((4096 - cap) & 12'hFFF));
    hw(desc_w(i) + 3, 16'h0000);
  endtask

  task automatic send(input int f, input int len, input logic crc_ok, input logic ferr);
    for (int k = 0; k < len; k++) begin
      logic took;
      rx_valid = 1'b1; rx_data = dat(f, k); rx_last = (k == len - 1);
      rx_crc_ok = crc_ok; rx_frame_err = ferr;
      took = 1'b0;
      while (!took) begin
        took = rx_ready;
        @(negedge clk);
      end
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic wait_evt(input int i0, input int m0, input int lim);
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      if (int_cnt != i0 || miss_cnt != m0) break;
    end
  endtask

  task automatic frame(input int f, input int len, input int cap,
                       input logic crc_ok, input logic ferr);
    int i0, m0, stored, mism_w;
    logic [7:0] fl;
    logic [15:0] expw, gotw;
    arm(exp_idx, cap, 1'b1);
    i0 = int_cnt; m0 = miss_cnt;
    send(f, len, crc_ok, ferr);
    wait_evt(i0, m0, 400);
    stored = (len < cap) ? len : cap;
    chk(int_cnt == i0 + 1 && miss_cnt == m0, "R9 one interrupt per frame", int_cnt - i0, 1);
    chk(first_addr == 24'(16'h0100 + 8 * exp_idx + 2), "R1 first access is flag read",
        int'(first_addr), 16'h0100 + 8 * exp_idx + 2);
    chk(mem[desc_w(exp_idx) + 3] == 16'(stored), "R5 message length",
        int'(mem[desc_w(exp_idx) + 3]), stored);
    fl = 8'h03;
    if (!crc_ok)   fl = fl | 8'h08;
    if (ferr)      fl = fl | 8'h20;
    if (len > cap) fl = fl | 8'h10;
    if (!crc_ok || ferr || len > cap) fl = fl | 8'h40;
    chk(mem[desc_w(exp_idx) + 1] == {fl, 8'h00}, "R6 R7 R4 flag word",
        int'(mem[desc_w(exp_idx) + 1]), int'({fl, 8'h00}));
    mism_w = -1; gotw = '0; expw = '0;
    for (int w = 0; w < (cap + 1) / 2 + 2; w++) begin
      logic [15:0] e;
      e[7:0]  = (2 * w < stored)     ? dat(f, 2 * w)     : 8'hC3;
      e[15:8] = (2 * w + 1 < stored) ? dat(f, 2 * w + 1) : 8'hA5;
      if (mism_w < 0 && mem[buf_w(exp_idx) + w] != e) begin
        mism_w = w; gotw = mem[buf_w(exp_idx) + w]; expw = e;
      end
    end
    chk(mism_w < 0, "R3 R4 buffer contents", int'(gotw), int'(expw));
    exp_idx = (exp_idx + 1) & ring_mask_b;
  endtask

  initial begin
    int f, i0, m0, w0;
    int caps[4] = '{15, 16, 32, 33};
    for (int a = 0; a < 4096; a++) mem[a] = 16'h0000;
    repeat (4) @(negedge clk);
    chk(rx_ready == 1'b0 && mem_req == 1'b0, "R11 reset idle outputs", {rx_ready, mem_req}, 0);
    chk(rx_int == 1'b0 && rx_miss == 1'b0, "R9 reset pulses low", {rx_int, rx_miss}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    f = 0;
    for (int ci = 0; ci < 4; ci++)
      for (int len = 1; len <= 36; len++) begin
        frame(f, len, caps[ci], (f % 5) != 0, (f % 7) == 3);
        f++;
      end

    // R2: host-owned descriptor
    arm(exp_idx, 16, 1'b0);
    i0 = int_cnt; m0 = miss_cnt; w0 = wr_cnt;
    send(f, 10, 1'b1, 1'b0);
    wait_evt(i0, m0, 200);
    repeat (4) @(negedge clk);
    chk(miss_cnt == m0 + 1 && int_cnt == i0, "R2 miss pulse only", miss_cnt - m0, 1);
    chk(wr_cnt == w0, "R2 no memory write", wr_cnt - w0, 0);
    chk(mem[desc_w(exp_idx) + 1] == 16'h0000, "R2 flag word untouched",
        int'(mem[desc_w(exp_idx) + 1]), 0);
    frame(f + 1, 20, 16, 1'b1, 1'b0);  // same index reused (R2, R8)
    f += 2;

    // R10: stopped
    run = 1'b0;
    arm(exp_idx, 16, 1'b1);
    i0 = int_cnt; m0 = miss_cnt; w0 = wr_cnt;
    send(f, 12, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    chk(int_cnt == i0 && miss_cnt == m0, "R10 no pulses while stopped", int_cnt - i0, 0);
    chk(wr_cnt == w0, "R10 no writes while stopped", wr_cnt - w0, 0);
    chk(mem[desc_w(exp_idx) + 1] == 16'h8000, "R10 descriptor still owned",
        int'(mem[desc_w(exp_idx) + 1]), 16'h8000);
    run = 1'b1;
    frame(f + 1, 8, 16, 1'b1, 1'b0);
    f += 2;

    // R8: smaller ring, wrap over two descriptors
    ring_len_word = {3'd1, 13'h0000};
    ring_mask_b = 1;
    exp_idx = exp_idx & 1;
    for (int n = 0; n < 6; n++) begin
      frame(f, 9 + n, 16, 1'b1, 1'b0);
      f++;
    end

    chk(hs_bad == 0, "R11 request held until ack", hs_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule